// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. A down-counter loses one unit on every slow tick (nominally one tick per 10 ms) while the watchdog is enabled. If software does not reload the counter in time, the block asks the chip for a system reset. One tick before that happens it can raise a warning interrupt. Software steers the block only by writing fixed 16-bit key words. The enable, disable and status registers read back coded words, not single bits. This makes a stray write from a runaway program very unlikely to stop the timer or fake a reload.

The block sits on a simple synchronous register bus with byte offsets. Writes take effect at the clock edge that samples them. Reads are combinational from the current address. The tick input is a one-cycle enable that already lives in this clock domain. A debug-mode input stops expiry while a debugger is attached, unless software has set the override bit.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is disabled and the disable-2 word at offset 0x0C reads 0xDABE. The counter and the timeout register both hold the reset timeout (6000 by default) and the counter does not move. The status word at 0x10, event bit 0 at 0x20, mask bit 0 at 0x24 and the interrupt output are all zero.
- R2: Writing exactly 0xFEED to offset 0x00 loads the counter from the timeout register at that clock edge. Writing any other value to 0x00 leaves the counter unchanged.
- R3: The timeout register at 0x04 keeps bits 14:0 of the written word and drops bit 15. It reads back as the 15-bit value with bit 15 at zero.
- R4: The watchdog is disabled when 0x2BAD is written to 0x08 and the next write to 0x0C is 0xCAFE. Writes to other offsets in between do not break this sequence. Any other value written to 0x08 or 0x0C cancels it. Offset 0x0C reads 0x0000 while the watchdog is enabled and 0xDABE while it is disabled.
- R5: If 0xCAFE is written to 0x0C without a pending 0x2BAD, the write has no effect and the watchdog stays enabled.
- R6: Writing 0xACED to 0x1C enables the watchdog and leaves the counter value unchanged. Any other value written there has no effect.
- R7: While the watchdog is enabled, each tick lowers the counter by one. While it is disabled, the counter is frozen. Offset 0x14 returns the counter in bits 14:0. Bit 15 is 1 exactly in a cycle where the watchdog is enabled and the tick input is high.
- R8: A tick that arrives with the watchdog enabled and the counter at 1 or 0 causes an expiry. At that edge the counter reloads from the timeout register and the status word becomes 0xCFE8. The reset-request output is high for the cycle that follows.
- R9: Writing 0xE8B4 to 0x10 returns the status word to 0x0000. If an expiry happens in the same cycle, the expiry wins.
- R10: A tick that takes the counter from 2 to 1 sets event bit 0 at 0x20. Writing a word with bit 0 set to 0x20 clears the event. If a set and a clear happen in the same cycle, the set wins.
- R11: The interrupt output equals event bit 0 AND mask bit 0. Mask bit 0 is stored at 0x24 and reads back from there.
- R12: Writing a word with bit 0 set to 0x28 sets the event bit. Offset 0x28 always reads 0.
- R13: While the debug-mode input is high and override bit 0 at 0x18 is clear, a tick at count 1 or 0 does not cause an expiry and the counter holds. When override bit 0 is set, the expiry happens as usual. Bit 1 of 0x18 reads the debug-mode input.
- R14: If a 0xFEED reload and a tick fall in the same cycle, the reload wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (6) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr, combinational |
| tick_i | input | 1 | One-cycle count enable, one per 10 ms |
| dbg_mode_i | input | 1 | Debug-mode indication |
| warn_irq_o | output | 1 | Pre-expiry warning interrupt, level |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the inputs are synchronous to the block clock. Each bus write lasts exactly one cycle, and the tick input is a clean one-cycle pulse. They do not assume ticks are spaced apart, so a short timeout can expire on back-to-back ticks. The stimulus drives every input from the falling edge and gives each write a single cycle. It also sets the timeout to small values so that warnings, expiries and debug holds all happen within a few ticks. The reference model computes the expected read data and outputs in every cycle of the test.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
   // byte offsets on the register bus; software decodes these
   localparam logic [7:0] OFS_FEED    = 8'h00;
   localparam logic [7:0] OFS_TMO     = 8'h04;
   localparam logic [7:0] OFS_ARM     = 8'h08;
   localparam logic [7:0] OFS_DIS     = 8'h0C;
   localparam logic [7:0] OFS_STAT    = 8'h10;
   localparam logic [7:0] OFS_CNT     = 8'h14;
   localparam logic [7:0] OFS_DBG     = 8'h18;
   localparam logic [7:0] OFS_RESUME  = 8'h1C;
   localparam logic [7:0] OFS_EVT     = 8'h20;
   localparam logic [7:0] OFS_MASK    = 8'h24;
   localparam logic [7:0] OFS_FORCE   = 8'h28;

   // key words
   localparam logic [15:0] KEY_FEED   = 16'hFEED;
   localparam logic [15:0] KEY_ARM    = 16'h2BAD;
   localparam logic [15:0] KEY_DIS    = 16'hCAFE;
   localparam logic [15:0] KEY_RESUME = 16'hACED;
   localparam logic [15:0] KEY_STCLR  = 16'hE8B4;

   // coded read-back words
   localparam logic [15:0] CODE_OFF   = 16'hDABE;
   localparam logic [15:0] CODE_ON    = 16'h0000;
   localparam logic [15:0] CODE_FIRED = 16'hCFE8;
   localparam logic [15:0] CODE_CALM  = 16'h0000;
endpackage

// File: rtl/kwdt_ctrl.sv
`timescale 1ns/1ps
module kwdt_ctrl
   import kwdt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 15,
   parameter int RST_TIMEOUT = 6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        addr8,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic              en_q,
   output logic              arm_q,
   output logic              st_q,
   output logic              msk_q,
   output logic              ovr_q,
   output logic [CNT_W-1:0]  tmo_q,
   output logic              feed_o,
   output logic              fset_o,
   output logic              eclr_o
);
   logic hit_tmo, hit_arm, hit_dis, hit_stat, hit_dbg, hit_res, hit_msk;

   always_comb begin
      hit_tmo  = wr_en && (addr8 == OFS_TMO);
      hit_arm  = wr_en && (addr8 == OFS_ARM);
      hit_dis  = wr_en && (addr8 == OFS_DIS);
      hit_stat = wr_en && (addr8 == OFS_STAT);
      hit_dbg  = wr_en && (addr8 == OFS_DBG);
      hit_res  = wr_en && (addr8 == OFS_RESUME);
      hit_msk  = wr_en && (addr8 == OFS_MASK);
      feed_o   = wr_en && (addr8 == OFS_FEED) && (wdata == KEY_FEED);
      fset_o   = wr_en && (addr8 == OFS_FORCE) && wdata[0];
      eclr_o   = wr_en && (addr8 == OFS_EVT) && wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         arm_q <= 1'b0;
         st_q  <= 1'b0;
         msk_q <= 1'b0;
         ovr_q <= 1'b0;
         tmo_q <= CNT_W'(RST_TIMEOUT);
      end else begin
         if (hit_tmo) tmo_q <= wdata[CNT_W-1:0];

         if (hit_arm)      arm_q <= (wdata == KEY_ARM);
         else if (hit_dis) arm_q <= 1'b0;

         if (hit_dis && (wdata == KEY_DIS) && arm_q)  en_q <= 1'b0;
         else if (hit_res && (wdata == KEY_RESUME))   en_q <= 1'b1;

         if (expire)                                   st_q <= 1'b1;
         else if (hit_stat && (wdata == KEY_STCLR))    st_q <= 1'b0;

         if (hit_msk) msk_q <= wdata[0];
         if (hit_dbg) ovr_q <= wdata[0];
      end
   end
endmodule

// File: rtl/kwdt_count.sv
`timescale 1ns/1ps
module kwdt_count #(
   parameter int CNT_W       = 15,
   parameter int RST_TIMEOUT = 6000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             feed,
   input  logic             tick,
   input  logic             en,
   input  logic             allow_exp,
   input  logic [CNT_W-1:0] tmo,
   output logic [CNT_W-1:0] cnt_q,
   output logic             warn_o,
   output logic             expire_o,
   output logic             rst_req_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   logic step, at_end;

   always_comb begin
      step     = en && tick && !feed;
      at_end   = (cnt_q <= ONE);
      expire_o = step && at_end && allow_exp;
      warn_o   = step && (cnt_q == TWO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= CNT_W'(RST_TIMEOUT);
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= expire_o;
         if (feed)                  cnt_q <= tmo;
         else if (expire_o)         cnt_q <= tmo;
         else if (step && !at_end)  cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/kwdt_event.sv
`timescale 1ns/1ps
module kwdt_event #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic warn,
   input  logic fset,
   input  logic eclr,
   input  logic msk,
   output logic ev_q,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ev_q <= 1'b0;
      else if (warn || fset) ev_q <= 1'b1;
      else if (eclr)         ev_q <= 1'b0;
   end

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ev_q && msk;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = ev_q && msk;
      end
   endgenerate
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 15,
   parameter int RST_TIMEOUT = 6000,
   parameter bit REG_IRQ     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_i,
   input  logic              dbg_mode_i,
   output logic              warn_irq_o,
   output logic              sys_rst_req_o
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("kwdt_top: key words need DATA_W of 16");
      end
      if (CNT_W >= DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("kwdt_top: CNT_W must lie in 2..DATA_W-1");
      end
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
         $error("kwdt_top: ADDR_W must lie in 6..8");
      end
      if (RST_TIMEOUT < 0 || RST_TIMEOUT > CNT_MAX) begin : g_bad_tmo
         $error("kwdt_top: RST_TIMEOUT exceeds counter range");
      end
   endgenerate

   logic [7:0]       addr8;
   logic             en_q, arm_q, st_q, msk_q, ovr_q, ev_q;
   logic [CNT_W-1:0] tmo_q, cnt_q;
   logic             feed, fset, eclr, warn, expire, allow_exp;

   assign addr8     = 8'(bus_addr);
   assign allow_exp = !dbg_mode_i || ovr_q;

   kwdt_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RST_TIMEOUT(RST_TIMEOUT)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_we),
      .addr8  (addr8),
      .wdata  (bus_wdata),
      .expire (expire),
      .en_q   (en_q),
      .arm_q  (arm_q),
      .st_q   (st_q),
      .msk_q  (msk_q),
      .ovr_q  (ovr_q),
      .tmo_q  (tmo_q),
      .feed_o (feed),
      .fset_o (fset),
      .eclr_o (eclr)
   );

   kwdt_count #(.CNT_W(CNT_W), .RST_TIMEOUT(RST_TIMEOUT)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .feed      (feed),
      .tick      (tick_i),
      .en        (en_q),
      .allow_exp (allow_exp),
      .tmo       (tmo_q),
      .cnt_q     (cnt_q),
      .warn_o    (warn),
      .expire_o  (expire),
      .rst_req_q (sys_rst_req_o)
   );

   kwdt_event #(.REG_IRQ(REG_IRQ)) u_event (
      .clk   (clk),
      .rst_n (rst_n),
      .warn  (warn),
      .fset  (fset),
      .eclr  (eclr),
      .msk   (msk_q),
      .ev_q  (ev_q),
      .irq_o (warn_irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (addr8)
         OFS_TMO:  bus_rdata[CNT_W-1:0] = tmo_q;
         OFS_DIS:  bus_rdata = en_q ? CODE_ON : CODE_OFF;
         OFS_STAT: bus_rdata = st_q ? CODE_FIRED : CODE_CALM;
         OFS_CNT: begin
            bus_rdata[CNT_W-1:0]  = cnt_q;
            bus_rdata[DATA_W-1]   = en_q && tick_i;
         end
         OFS_DBG:  bus_rdata[1:0] = {dbg_mode_i, ovr_q};
         OFS_EVT:  bus_rdata[0]   = ev_q;
         OFS_MASK: bus_rdata[0]   = msk_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/kwdt_chk.sv
`timescale 1ns/1ps
module kwdt_chk
   import kwdt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic [DATA_W-1:0] wdata,
   input logic              tick,
   input logic              dbg,
   input logic              rst_req,
   input logic              en,
   input logic              arm,
   input logic              st,
   input logic              ovr,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  tmo
);
   logic [7:0] a8;
   logic       feed_w;
   assign a8     = 8'(addr);
   assign feed_w = we && (a8 == OFS_FEED) && (wdata == KEY_FEED);

   assert_feed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      feed_w |=> (cnt == $past(tmo)));

   assert_tmo_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && a8 == OFS_TMO) |=> (tmo == $past(wdata[CNT_W-1:0])));

   assert_lone_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && a8 == OFS_DIS && wdata == KEY_DIS && !arm) |=> (en == $past(en)));

   assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && a8 == OFS_RESUME && wdata == KEY_RESUME) |=> en);

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !feed_w) |=> $stable(cnt));

   assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !feed_w && cnt > CNT_W'(1)) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   assert_fire_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> st);

   assert_fire_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == $past(tmo)));

   assert_dbg_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && dbg && !ovr) |=> !rst_req);
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (bus_addr),
   .we      (bus_we),
   .wdata   (bus_wdata),
   .tick    (tick_i),
   .dbg     (dbg_mode_i),
   .rst_req (sys_rst_req_o),
   .en      (en_q),
   .arm     (arm_q),
   .st      (st_q),
   .ovr     (ovr_q),
   .cnt     (cnt_q),
   .tmo     (tmo_q)
);

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
module kwdt_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        we = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        tick = 1'b0;
   logic        dbg = 1'b0;
   logic        irq, rreq;

   int checks = 0;
   int fails  = 0;

   // behavioural reference state
   int m_en, m_arm, m_st, m_msk, m_ovr, m_ev, m_rreq;
   int m_cnt, m_tmo;

   always #2.5 clk = ~clk;

   kwdt_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .tick_i(tick),
      .dbg_mode_i(dbg), .warn_irq_o(irq), .sys_rst_req_o(rreq)
   );

   task automatic m_reset();
      m_en = 0; m_arm = 0; m_st = 0; m_msk = 0; m_ovr = 0; m_ev = 0;
      m_rreq = 0; m_cnt = 6000; m_tmo = 6000;
   endtask

   initial m_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_reset();
      else begin
         int n_cnt, ex, wn, fd;
         int o_en, o_arm, o_ovr, o_tmo;
         o_en = m_en; o_arm = m_arm; o_ovr = m_ovr; o_tmo = m_tmo;
         fd = (we && addr == 6'h00 && wdata == 16'hFEED) ? 1 : 0;
         ex = 0; wn = 0; n_cnt = m_cnt;
         if (fd) n_cnt = o_tmo;
         else if (o_en && tick) begin
            if (m_cnt <= 1) begin
               if (!dbg || o_ovr) begin ex = 1; n_cnt = o_tmo; end
            end else begin
               if (m_cnt == 2) wn = 1;
               n_cnt = m_cnt - 1;
            end
         end
         m_cnt = n_cnt;
         m_rreq = ex;
         if (we) begin
            case (addr)
               6'h04: m_tmo = wdata & 16'h7FFF;
               6'h08: m_arm = (wdata == 16'h2BAD) ? 1 : 0;
               6'h0C: begin
                  if (wdata == 16'hCAFE && o_arm) m_en = 0;
                  m_arm = 0;
               end
               6'h10: if (wdata == 16'hE8B4) m_st = 0;
               6'h18: m_ovr = wdata[0];
               6'h1C: if (wdata == 16'hACED) m_en = 1;
               6'h24: m_msk = wdata[0];
               default: ;
            endcase
         end
         if (ex) m_st = 1;
         if (wn || (we && addr == 6'h28 && wdata[0])) m_ev = 1;
         else if (we && addr == 6'h20 && wdata[0]) m_ev = 0;
      end
   end

   function automatic logic [15:0] m_read();
      case (addr)
         6'h04: return 16'(m_tmo);
         6'h0C: return m_en ? 16'h0000 : 16'hDABE;
         6'h10: return m_st ? 16'hCFE8 : 16'h0000;
         6'h14: return {(m_en != 0 && tick), 15'(m_cnt)};
         6'h18: return {14'd0, dbg, m_ovr[0]};
         6'h20: return {15'd0, m_ev[0]};
         6'h24: return {15'd0, m_msk[0]};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [15:0] er;
      logic ei;
      er = m_read();
      ei = (m_ev != 0) && (m_msk != 0);
      checks++;
      if (rdata !== er) begin
         fails++;
         $display("FAIL %s rdata @%h: actual %h expected %h", tag, addr, rdata, er);
      end
      checks++;
      if (irq !== ei) begin
         fails++;
         $display("FAIL %s irq: actual %b expected %b", tag, irq, ei);
      end
      checks++;
      if (rreq !== m_rreq[0]) begin
         fails++;
         $display("FAIL %s reset request: actual %b expected %b", tag, rreq, m_rreq[0]);
      end
   endtask

   task automatic step(input logic [5:0] a, input logic w, input logic [15:0] d,
                       input logic t, input string tag);
      @(negedge clk);
      addr = a; we = w; wdata = d; tick = t;
      #1;
      compare(tag);
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
      step(a, 1'b1, d, 1'b0, tag);
   endtask

   task automatic rd(input logic [5:0] a, input string tag);
      step(a, 1'b0, 16'h0, 1'b0, tag);
   endtask

   task automatic tk(input logic [5:0] a, input string tag);
      step(a, 1'b0, 16'h0, 1'b1, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(6'h0C, "R1"); rd(6'h10, "R1"); rd(6'h14, "R1"); rd(6'h04, "R1");
      rd(6'h20, "R1"); rd(6'h24, "R1");
      tk(6'h14, "R1"); rd(6'h14, "R1");
      // R3 bit 15 dropped
      wr(6'h04, 16'h8005, "R3"); rd(6'h04, "R3");
      // R2 wrong key then right key
      wr(6'h00, 16'hFEEE, "R2"); rd(6'h14, "R2");
      wr(6'h00, 16'hFEED, "R2"); rd(6'h14, "R2");
      // R7 frozen while disabled
      tk(6'h14, "R7"); tk(6'h14, "R7"); rd(6'h14, "R7");
      // R6 resume keys
      wr(6'h1C, 16'hACEE, "R6"); rd(6'h0C, "R6");
      wr(6'h1C, 16'hACED, "R6"); rd(6'h0C, "R6"); rd(6'h14, "R6");
      // R11 mask, R7 ticks, R10 warning at 2->1
      wr(6'h24, 16'h0001, "R11"); rd(6'h24, "R11");
      tk(6'h14, "R7"); tk(6'h14, "R7"); tk(6'h14, "R7");
      rd(6'h20, "R10");
      tk(6'h14, "R10"); rd(6'h20, "R10"); rd(6'h20, "R11");
      wr(6'h20, 16'h0001, "R10"); rd(6'h20, "R10");
      // R8 expiry at count 1
      tk(6'h14, "R8"); rd(6'h10, "R8"); rd(6'h14, "R8");
      // R9 status clear (wrong key first)
      wr(6'h10, 16'hE8B5, "R9"); rd(6'h10, "R9");
      wr(6'h10, 16'hE8B4, "R9"); rd(6'h10, "R9");
      // R12 force
      wr(6'h24, 16'h0000, "R11"); wr(6'h28, 16'h0001, "R12");
      rd(6'h28, "R12"); rd(6'h20, "R12");
      wr(6'h24, 16'h0001, "R12"); rd(6'h20, "R12");
      wr(6'h20, 16'h0001, "R12"); rd(6'h20, "R12");
      // R13 debug hold
      dbg = 1'b1;
      rd(6'h18, "R13");
      tk(6'h14, "R13"); tk(6'h14, "R13"); tk(6'h14, "R13"); tk(6'h14, "R13");
      tk(6'h14, "R13"); tk(6'h14, "R13"); rd(6'h14, "R13"); rd(6'h10, "R13");
      wr(6'h18, 16'h0001, "R13"); rd(6'h18, "R13");
      tk(6'h14, "R13"); rd(6'h10, "R13"); rd(6'h14, "R13");
      wr(6'h18, 16'h0000, "R13");
      dbg = 1'b0;
      wr(6'h10, 16'hE8B4, "R9"); wr(6'h20, 16'h0001, "R10");
      // R14 feed and tick together
      tk(6'h14, "R14");
      step(6'h00, 1'b1, 16'hFEED, 1'b1, "R14"); rd(6'h14, "R14");
      // R5 lone disable key
      wr(6'h0C, 16'hCAFE, "R5"); rd(6'h0C, "R5");
      // R4 broken sequence then good sequences
      wr(6'h08, 16'h2BAD, "R4"); wr(6'h0C, 16'h1234, "R4");
      wr(6'h0C, 16'hCAFE, "R4"); rd(6'h0C, "R4");
      wr(6'h08, 16'h2BAD, "R4"); wr(6'h08, 16'h0000, "R4");
      wr(6'h0C, 16'hCAFE, "R4"); rd(6'h0C, "R4");
      wr(6'h08, 16'h2BAD, "R4"); wr(6'h24, 16'h0000, "R4");
      wr(6'h0C, 16'hCAFE, "R4"); rd(6'h0C, "R4");
      tk(6'h14, "R7"); rd(6'h14, "R7");
      // R8 back-to-back expiry with short timeout
      wr(6'h1C, 16'hACED, "R6"); wr(6'h04, 16'h0001, "R3");
      wr(6'h00, 16'hFEED, "R2");
      tk(6'h14, "R8"); tk(6'h14, "R8"); rd(6'h10, "R8"); rd(6'h10, "R8");
      repeat (4) rd(6'h14, "R7");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule